// File: doc/BRIEF.md
# Pipeline Hazard Stall and Bubble Controller

This block holds the hazard control for a five-stage in-order pipeline made of fetch, decode, execute, memory and write-back stages. It reads the opcodes held in the decode, execute and memory pipeline registers. It also reads the memory-destination register of the instruction in execute, the two source registers of the instruction in decode, and the branch outcome flag computed in execute. From these it drives four requests: hold the fetch register, hold the decode register, squash the decode register to a bubble, and squash the execute register to a bubble. The pipeline registers act on these requests at their next clock edge.

The block has no state. Every output depends only on the present inputs. Three hazards are recognised:
- a loaded value that the very next instruction needs (a load or a pop);
- a conditional jump that was predicted taken but is found not taken;
- a return whose target address is not yet known.

When several of these arise in the same cycle, the block merges the requests in a fixed way. The load-use hold has priority over the return squash. As a result, decode is never told to hold and squash at once, and the return waits one more cycle in decode. A return that sits at the target of a mispredicted jump is handled as a plain misprediction. Holding fetch in that case does no harm, because the next PC comes from the fall-through value in the memory stage.

Opcodes are 4 bits wide. The block decodes four of them: load = 4'h5, jump = 4'h7, return = 4'h9 and pop = 4'hB. Register IDs are 4 bits wide, and 4'hF means "no register".

Top module: `hazard_ctrl`

## Requirements
- R1: A load-use hazard exists when `e_opc` is load (4'h5) or pop (4'hB) and `e_dst_mem` equals `d_src_a` or `d_src_b`. In that case `f_stall`, `d_stall` and `e_bubble` are 1, and `d_bubble` is 0.
- R2: The ID 4'hF never produces a match. When `e_dst_mem` is 4'hF, no load-use hazard is raised, even if a decode source is also 4'hF.
- R3: A return (4'h9) in any of `d_opc`, `e_opc` or `m_opc`, with no other hazard present, gives `f_stall`=1 and `d_bubble`=1, with `d_stall`=0 and `e_bubble`=0. A return that moves through decode, execute and memory therefore costs three held fetch cycles.
- R4: When every hazard condition is absent, all four outputs are 0. This covers a return that has only reached write-back and a return sitting in `w_opc`, which the block does not watch.
- R5: A jump (4'h7) in `e_opc` with `e_cond`=0 gives `d_bubble`=1 and `e_bubble`=1, with `f_stall`=0 and `d_stall`=0. This cancels two slots. When `e_cond` is 1, the jump raises nothing.
- R6: Only load and pop in execute can create a load-use hazard. Any other opcode in `e_opc`, even with a matching `e_dst_mem`, leaves `d_stall` at 0.
- R7: A mispredicted jump in execute together with a return in decode gives `f_stall`=1, `d_bubble`=1 and `e_bubble`=1, with `d_stall`=0.
- R8: A load-use hazard together with a return in decode gives `f_stall`=1, `d_stall`=1 and `e_bubble`=1, with `d_bubble`=0.
- R9: `d_stall` and `d_bubble` are never 1 at the same time.
- R10: The outputs follow the inputs within the same cycle, with no clock edge in between.

Ports: the table lists every input and output in port-list order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| d_opc | input | 4 | Opcode held in the decode register |
| e_opc | input | 4 | Opcode held in the execute register |
| m_opc | input | 4 | Opcode held in the memory register |
| e_dst_mem | input | 4 | Memory-destination register ID of the execute instruction |
| d_src_a | input | 4 | First source register ID of the decode instruction |
| d_src_b | input | 4 | Second source register ID of the decode instruction |
| e_cond | input | 1 | Branch condition computed in execute (1 = taken) |
| f_stall | output | 1 | Hold the fetch register |
| d_stall | output | 1 | Hold the decode register |
| d_bubble | output | 1 | Squash the decode register to a bubble |
| e_bubble | output | 1 | Squash the execute register to a bubble |

## Verification
Every result is due in the same cycle as the stimulus that causes it, because no register lies between the inputs and the outputs. The pipeline acts on the requests only at the following edge, so the request must already be correct before that edge arrives. The bench changes the inputs at the falling clock edge and reads the outputs one nanosecond later, well before the next rising edge. One check also changes the inputs with no clock edge at all, which shows that the response does not wait for one.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int OPC_W = 4;
    localparam int RID_W = 4;

    localparam logic [OPC_W-1:0] OPC_LOAD = 4'h5;
    localparam logic [OPC_W-1:0] OPC_JUMP = 4'h7;
    localparam logic [OPC_W-1:0] OPC_RET  = 4'h9;
    localparam logic [OPC_W-1:0] OPC_POP  = 4'hB;

    localparam logic [RID_W-1:0] RID_NONE = '1;

    // Hazard conditions found in one cycle.
    typedef struct packed {
        logic load_use;
        logic ret_flight;
        logic mispredict;
    } hz_flags_t;

    // Requests sent to the pipeline registers.
    typedef struct packed {
        logic f_stall;
        logic d_stall;
        logic d_bubble;
        logic e_bubble;
    } pipe_ctl_t;

    function automatic logic writes_from_mem(input logic [OPC_W-1:0] opc);
        return (opc == OPC_LOAD) || (opc == OPC_POP);
    endfunction

    function automatic logic rid_hit(input logic [RID_W-1:0] a,
                                     input logic [RID_W-1:0] b);
        return (a != RID_NONE) && (a == b);
    endfunction

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
    import hz_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic [RID_W-1:0]              dst,
    input  logic [NUM_SRC-1:0][RID_W-1:0] srcs,
    output logic                          hit
);
    logic [NUM_SRC-1:0] per_src;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
        assign per_src[i] = rid_hit(dst, srcs[i]);
    end

    assign hit = |per_src;
endmodule

// File: rtl/hz_detect.sv
module hz_detect
    import hz_pkg::*;
#(
    parameter int NUM_SRC     = 2,
    parameter int NUM_RET_STG = 3
) (
    input  logic [NUM_RET_STG-1:0][OPC_W-1:0] watch_opc,
    input  logic [OPC_W-1:0]                  exe_opc,
    input  logic [RID_W-1:0]                  exe_dst_mem,
    input  logic [NUM_SRC-1:0][RID_W-1:0]     dec_srcs,
    input  logic                              exe_cond,
    output hz_flags_t                         flags
);
    logic               src_hit;
    logic [NUM_RET_STG-1:0] ret_at;

    hz_src_match #(.NUM_SRC(NUM_SRC)) u_match (
        .dst  (exe_dst_mem),
        .srcs (dec_srcs),
        .hit  (src_hit)
    );

    for (genvar s = 0; s < NUM_RET_STG; s++) begin : g_ret
        assign ret_at[s] = (watch_opc[s] == OPC_RET);
    end

    always_comb begin
        flags.load_use   = writes_from_mem(exe_opc) && src_hit;
        flags.ret_flight = |ret_at;
        flags.mispredict = (exe_opc == OPC_JUMP) && !exe_cond;
    end
endmodule

// File: rtl/hz_resolve.sv
module hz_resolve
    import hz_pkg::*;
(
    input  hz_flags_t flags,
    output pipe_ctl_t ctl
);
    always_comb begin
        ctl.f_stall  = flags.load_use || flags.ret_flight;
        ctl.d_stall  = flags.load_use;
        // load-use wins over the return squash: decode holds instead
        ctl.d_bubble = flags.mispredict ||
                       (flags.ret_flight && !flags.load_use);
        ctl.e_bubble = flags.mispredict || flags.load_use;
    end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hz_pkg::*;
(
    input  logic [3:0] d_opc,
    input  logic [3:0] e_opc,
    input  logic [3:0] m_opc,
    input  logic [3:0] e_dst_mem,
    input  logic [3:0] d_src_a,
    input  logic [3:0] d_src_b,
    input  logic       e_cond,
    output logic       f_stall,
    output logic       d_stall,
    output logic       d_bubble,
    output logic       e_bubble
);
    localparam int NUM_SRC     = 2;
    localparam int NUM_RET_STG = 3;

    logic [NUM_RET_STG-1:0][OPC_W-1:0] watch_opc;
    logic [NUM_SRC-1:0][RID_W-1:0]     dec_srcs;
    hz_flags_t                         flags;
    pipe_ctl_t                         ctl;

    assign watch_opc = {m_opc, e_opc, d_opc};
    assign dec_srcs  = {d_src_b, d_src_a};

    hz_detect #(.NUM_SRC(NUM_SRC), .NUM_RET_STG(NUM_RET_STG)) u_detect (
        .watch_opc   (watch_opc),
        .exe_opc     (e_opc),
        .exe_dst_mem (e_dst_mem),
        .dec_srcs    (dec_srcs),
        .exe_cond    (e_cond),
        .flags       (flags)
    );

    hz_resolve u_resolve (
        .flags (flags),
        .ctl   (ctl)
    );

    assign f_stall  = ctl.f_stall;
    assign d_stall  = ctl.d_stall;
    assign d_bubble = ctl.d_bubble;
    assign e_bubble = ctl.e_bubble;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk (
    input logic [3:0] d_opc,
    input logic [3:0] e_opc,
    input logic [3:0] m_opc,
    input logic [3:0] e_dst_mem,
    input logic       e_cond,
    input logic       f_stall,
    input logic       d_stall,
    input logic       d_bubble,
    input logic       e_bubble
);
    always_comb begin
        AST_D_HOLD_XOR_SQUASH: assert (!(d_stall && d_bubble)) else $error("d both"); // R9
        AST_DHOLD_WITH_FHOLD: assert (!d_stall || (f_stall && e_bubble)) else $error("hold set"); // R1
        AST_NONE_NEVER_HOLDS: assert (!(e_dst_mem == 4'hF && d_stall)) else $error("none hit"); // R2
        AST_RET_HOLDS_FETCH: assert (!(d_opc == 4'h9 || e_opc == 4'h9 || m_opc == 4'h9) || f_stall) else $error("ret"); // R3
        AST_MISP_SQUASHES_E: assert (!(e_opc == 4'h7 && !e_cond) || e_bubble) else $error("misp"); // R5
        AST_ONLY_LOADS_HOLD_D: assert (!d_stall || e_opc == 4'h5 || e_opc == 4'hB) else $error("opc"); // R6
    end
endmodule

bind hazard_ctrl hazard_ctrl_chk u_chk (
    .d_opc     (d_opc),
    .e_opc     (e_opc),
    .m_opc     (m_opc),
    .e_dst_mem (e_dst_mem),
    .e_cond    (e_cond),
    .f_stall   (f_stall),
    .d_stall   (d_stall),
    .d_bubble  (d_bubble),
    .e_bubble  (e_bubble)
);

// File: tb/sim_hazard_ctrl.sv
module sim_hazard_ctrl;
    localparam logic [3:0] NOP = 4'h0, ALU = 4'h6, LD = 4'h5, JMP = 4'h7,
                           RET = 4'h9, POP = 4'hB, NONE = 4'hF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] d_opc = NOP, e_opc = NOP, m_opc = NOP;
    logic [3:0] e_dst_mem = NONE, d_src_a = NONE, d_src_b = NONE;
    logic       e_cond = 1'b1;
    logic f_stall, d_stall, d_bubble, e_bubble;
    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    hazard_ctrl u0 (
        .d_opc(d_opc), .e_opc(e_opc), .m_opc(m_opc), .e_dst_mem(e_dst_mem),
        .d_src_a(d_src_a), .d_src_b(d_src_b), .e_cond(e_cond),
        .f_stall(f_stall), .d_stall(d_stall), .d_bubble(d_bubble), .e_bubble(e_bubble)
    );

    // expected bits: {f_stall, d_stall, d_bubble, e_bubble}
    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] got;
        got = {f_stall, d_stall, d_bubble, e_bubble};
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic drive(input logic [3:0] dop, input logic [3:0] eop, input logic [3:0] mop,
                         input logic [3:0] dst, input logic [3:0] sa, input logic [3:0] sb,
                         input logic cond);
        @(negedge clk);
        d_opc = dop; e_opc = eop; m_opc = mop;
        e_dst_mem = dst; d_src_a = sa; d_src_b = sb; e_cond = cond;
        #1;
    endtask

    task automatic t_idle();
        drive(NOP, NOP, NOP, NONE, NONE, NONE, 1'b1);
        check("R4 idle", 4'b0000);
    endtask

    task automatic t_load_use();
        drive(ALU, LD, NOP, 4'h3, 4'h3, 4'h1, 1'b1);
        check("R1 load src_a", 4'b1101);
        drive(ALU, POP, NOP, 4'h4, 4'h0, 4'h4, 1'b1);
        check("R1 pop src_b", 4'b1101);
        drive(ALU, LD, NOP, 4'h4, 4'h0, 4'h1, 1'b1);
        check("R1 no match", 4'b0000);
    endtask

    task automatic t_none_id();
        drive(ALU, LD, NOP, NONE, NONE, NONE, 1'b1);
        check("R2 none vs none", 4'b0000);
        drive(ALU, POP, NOP, NONE, 4'h2, NONE, 1'b1);
        check("R2 none vs src", 4'b0000);
    endtask

    task automatic t_other_writer();
        drive(ALU, ALU, NOP, 4'h2, 4'h2, 4'h2, 1'b1);
        check("R6 alu writer", 4'b0000);
        drive(ALU, RET, NOP, 4'h2, 4'h2, 4'h2, 1'b1);
        check("R6 ret in e with match", 4'b1010);
    endtask

    task automatic t_ret_walk();
        drive(RET, NOP, NOP, NONE, NONE, NONE, 1'b1);
        check("R3 ret in D", 4'b1010);
        drive(NOP, RET, NOP, NONE, NONE, NONE, 1'b1);
        check("R3 ret in E", 4'b1010);
        drive(NOP, NOP, RET, NONE, NONE, NONE, 1'b1);
        check("R3 ret in M", 4'b1010);
        drive(NOP, NOP, NOP, NONE, NONE, NONE, 1'b1);
        check("R4 ret past M", 4'b0000);
    endtask

    task automatic t_mispredict();
        drive(ALU, JMP, NOP, NONE, NONE, NONE, 1'b0);
        check("R5 not taken", 4'b0011);
        drive(ALU, JMP, NOP, NONE, NONE, NONE, 1'b1);
        check("R5 taken", 4'b0000);
    endtask

    task automatic t_combo_misp_ret();
        drive(RET, JMP, NOP, NONE, NONE, NONE, 1'b0);
        check("R7 misp with ret in D", 4'b1011);
    endtask

    task automatic t_combo_load_ret();
        drive(RET, LD, NOP, 4'h4, 4'h4, NONE, 1'b1);
        check("R8 load-use with ret in D", 4'b1101);
        drive(RET, POP, NOP, 4'h4, NONE, 4'h4, 1'b1);
        check("R9 pop with ret in D", 4'b1101);
    endtask

    task automatic t_same_cycle();
        drive(NOP, NOP, NOP, NONE, NONE, NONE, 1'b1);
        e_opc = JMP; e_cond = 1'b0;
        #1;
        check("R10 no edge, misp", 4'b0011);
        d_opc = RET; e_opc = LD; e_dst_mem = 4'h1; d_src_a = 4'h1;
        #1;
        check("R10 no edge, load-use", 4'b1101);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_load_use();
        t_none_id();
        t_other_writer();
        t_ret_walk();
        t_mispredict();
        t_combo_misp_ret();
        t_combo_load_ret();
        t_same_cycle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule